// File: doc/BRIEF.md
# Round-Robin Hardware Thread Switch Controller

This block decides which of several hardware threads owns a single execution core at any moment. It watches the core's instruction-retire pulses and the class of each retired instruction. From these it decides when the running thread gives up the core: its time slice runs out, it yields, or it halts. It then sequences the hand-over. The outgoing thread's architectural context (program counter, general registers and six condition flags) is captured from the datapath into a per-thread slot. The incoming thread's slot is then presented back for the datapath to load.

The time slice is a down counter that is refilled on every hand-over. It is refilled either with a fixed slice length or, in random mode, with a pseudo-random value between one and that length. The successor is the first thread that has not halted, searched upward from the thread above the current one and wrapping round. A halted thread is never saved again and never chosen again. When the last thread halts, the controller parks and raises a completion flag next to the total count of retired instructions.

Top module: `ts_switcher`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `cur_tid` is 0, both strobes and `all_done` are low and `insn_count` is 0. In the second cycle after release, `restore_stb` is high for thread 0.
- R2: Each thread's context slot starts as follows. The program counter in bits [PCW-1:0] is LOAD_ADDR. Register SP_IDX, at bits [PCW+SP_IDX*DW +: DW], holds STACK_TOP minus tid*STACK_STEP. All other registers and the flags in the top NFLAG bits are zero. The first restore of each thread presents this value.
- R3: A plain retire (`retire_kind` 0 or 3) in the running state decrements the slice counter. The retire that finds the counter at 1 instead starts a hand-over: `save_stb` is high for one cycle, and in the cycle after it `restore_stb` is high for the successor.
- R4: A yield retire (`retire_kind` 1) starts the same save-then-restore hand-over regardless of the counter value, and the counter is refilled.
- R5: The successor is the first thread, in the order cur+1, cur+2, ..., NT-1, 0, ..., cur, that has not halted. A lone live thread that yields or expires is saved and restored to itself.
- R6: A halt retire (`retire_kind` 2) marks the running thread halted and issues no save strobe. When another live thread exists, the next cycle raises `restore_stb` with `cur_tid` already at the successor.
- R7: When the last live thread halts, `all_done` rises in the next cycle and stays high. No strobe follows, and `cur_tid` and `insn_count` hold.
- R8: `ctx_in` is captured into the outgoing thread's slot in the cycle `save_stb` is high. A later restore of that thread presents exactly that value on `restore_ctx`.
- R9: Retire pulses arriving while a hand-over is in progress (save or restore cycle), in the start-up cycle, or after completion are ignored. They are not counted and do not move the slice counter.
- R10: In random mode each refill is (L mod q)+1, where L is a 16-bit LFSR. L resets to 0xACE1 and advances on every refill as L = {L[14:0], L[15]^L[13]^L[12]^L[10]}, taking the value before the advance. In fixed mode a refill loads q.
- R11: A `quantum` of 0 is treated as 1, so every plain retire ends the slice.
- R12: `insn_count` increments by one, in the following cycle, for every accepted retire of any kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quantum | input | QW | Slice length q (0 acts as 1) |
| rand_mode | input | 1 | Refill with a pseudo-random length in 1..q |
| retire | input | 1 | One instruction retired this cycle |
| retire_kind | input | 2 | 0/3 plain, 1 yield, 2 halt |
| ctx_in | input | CW | Outgoing context, sampled while `save_stb` is high |
| cur_tid | output | TW | Thread owning the core |
| save_stb | output | 1 | Datapath must present the outgoing context on `ctx_in` |
| restore_stb | output | 1 | Datapath must load `restore_ctx` for `cur_tid` |
| restore_ctx | output | CW | Stored context of `cur_tid` |
| all_done | output | 1 | Every thread has halted |
| insn_count | output | ICW | Total accepted retires |

## Verification
The hardest condition to reach from the ports is a hand-over decided while retire pulses keep arriving. The bench holds `retire` high through whole save and restore sequences, both with yields and with plain retires, so that the ignore rule and the counter freeze are exercised on every switch. Halts are timed from the bench's own model of which thread is running. This lets a thread in the middle of the order be removed first, and later the only remaining thread, so that skipping and self-switching appear in the same run. A random-mode phase with two slice lengths then compares every refill against the bench's own generator sequence.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_RESTORE = 3'd1,
    ST_RUN     = 3'd2,
    ST_SAVE    = 3'd3,
    ST_DONE    = 3'd4
  } ts_state_e;

  localparam logic [1:0] KIND_YIELD = 2'd1;
  localparam logic [1:0] KIND_HALT  = 2'd2;

  localparam int LFSR_W = 16;

endpackage

// File: rtl/ts_quantum.sv
module ts_quantum #(
  parameter int                 QW   = 8,
  parameter logic [15:0]        SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          dec_i,
  input  logic [QW-1:0] quantum_i,
  input  logic          rand_i,
  output logic          last_o
);
  import ts_pkg::*;

  logic [QW-1:0]     cnt_q, cnt_d;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [QW-1:0]     q_eff;
  logic [LFSR_W-1:0] q_ext;
  logic [LFSR_W-1:0] rem;
  logic [QW-1:0]     fill;
  logic              fb;

  always_comb begin
    q_eff  = (quantum_i == '0) ? QW'(1) : quantum_i;
    q_ext  = LFSR_W'(q_eff);
    rem    = lfsr_q % q_ext;
    fill   = rand_i ? (QW'(rem) + QW'(1)) : q_eff;
    fb     = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
    cnt_d  = cnt_q;
    lfsr_d = lfsr_q;
    if (load_i) begin
      cnt_d  = fill;
      lfsr_d = {lfsr_q[14:0], fb};
    end else if (dec_i) begin
      cnt_d  = cnt_q - QW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lfsr_q <= SEED;
    end else begin
      if (load_i || dec_i) cnt_q <= cnt_d;
      if (load_i)          lfsr_q <= lfsr_d;
    end
  end

  assign last_o = (cnt_q == QW'(1));

  // R10: a refill always lands in 1..q
  a_r10_reload_range: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q != '0) && (cnt_q <= $past(q_eff)));

  // R3: the counter is never stepped below one
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> (cnt_q > QW'(1)));

  // R11: a zero slice length refills to one
  a_r11_zero_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !rand_i && quantum_i == '0) |=> (cnt_q == QW'(1)));

endmodule

// File: rtl/ts_picker.sv
module ts_picker #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic [TW-1:0] cur_i,
  input  logic [NT-1:0] halted_i,
  output logic [TW-1:0] pick_o,
  output logic          found_o
);

  always_comb begin
    pick_o  = cur_i;
    found_o = 1'b0;
    for (int k = 1; k <= NT; k++) begin
      int idx;
      idx = int'(cur_i) + k;
      if (idx >= NT) idx = idx - NT;
      if (!found_o && !halted_i[idx]) begin
        pick_o  = TW'(idx);
        found_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ts_ctx_store.sv
module ts_ctx_store #(
  parameter int                NT         = 4,
  parameter int                TW         = 2,
  parameter int                PCW        = 16,
  parameter int                DW         = 32,
  parameter int                NREG       = 6,
  parameter int                NFLAG      = 6,
  parameter int                SP_IDX     = 4,
  parameter logic [PCW-1:0]    LOAD_ADDR  = 16'd1000,
  parameter int unsigned       STACK_TOP  = 128000,
  parameter int unsigned       STACK_STEP = 1000,
  localparam int               CW         = PCW + NREG*DW + NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [TW-1:0] wr_tid_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic [TW-1:0] rd_tid_i,
  output logic [CW-1:0] rd_data_o
);

  logic [NT-1:0][CW-1:0] slots;

  for (genvar t = 0; t < NT; t++) begin : g_slot
    localparam logic [DW-1:0] SP_INIT = DW'(STACK_TOP - STACK_STEP * t);
    localparam logic [CW-1:0] INIT_V  =
      (CW'(SP_INIT) << (PCW + SP_IDX*DW)) | CW'(LOAD_ADDR);

    logic [CW-1:0] slot_q;
    logic          slot_we;

    assign slot_we = wr_en_i && (wr_tid_i == TW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= INIT_V;
      else if (slot_we) slot_q <= wr_data_i;
    end

    assign slots[t] = slot_q;
  end

  assign rd_data_o = slots[rd_tid_i];

endmodule

// File: rtl/ts_switcher.sv
module ts_switcher #(
  parameter int             NT         = 4,
  parameter int             QW         = 8,
  parameter int             PCW        = 16,
  parameter int             DW         = 32,
  parameter int             NREG       = 6,
  parameter int             NFLAG      = 6,
  parameter int             SP_IDX     = 4,
  parameter int             ICW        = 32,
  parameter logic [PCW-1:0] LOAD_ADDR  = 16'd1000,
  parameter int unsigned    STACK_TOP  = 128000,
  parameter int unsigned    STACK_STEP = 1000,
  localparam int            TW         = (NT > 1) ? $clog2(NT) : 1,
  localparam int            CW         = PCW + NREG*DW + NFLAG
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [QW-1:0]  quantum,
  input  logic           rand_mode,
  input  logic           retire,
  input  logic [1:0]     retire_kind,
  input  logic [CW-1:0]  ctx_in,
  output logic [TW-1:0]  cur_tid,
  output logic           save_stb,
  output logic           restore_stb,
  output logic [CW-1:0]  restore_ctx,
  output logic           all_done,
  output logic [ICW-1:0] insn_count
);
  import ts_pkg::*;

  ts_state_e      state_q, state_d;
  logic [TW-1:0]  cur_q, cur_d;
  logic [TW-1:0]  nxt_q, nxt_d;
  logic [NT-1:0]  halted_q, halted_d;
  logic [ICW-1:0] icnt_q, icnt_d;

  logic          accept, is_halt, is_yield, is_plain, expire;
  logic          q_load, q_dec, q_last;
  logic [NT-1:0] cur_oh, scan_mask;
  logic [TW-1:0] pick;
  logic          found;

  // retire classification
  always_comb begin
    accept   = retire && (state_q == ST_RUN);
    is_halt  = accept && (retire_kind == KIND_HALT);
    is_yield = accept && (retire_kind == KIND_YIELD);
    is_plain = accept && !is_halt && !is_yield;
    expire   = is_plain && q_last;
    cur_oh   = NT'(1) << cur_q;
    scan_mask = halted_q | (is_halt ? cur_oh : '0);
    q_load   = (state_q == ST_INIT) || is_yield || expire || (is_halt && found);
    q_dec    = is_plain && !expire;
  end

  ts_picker #(.NT(NT), .TW(TW)) u_picker (
    .cur_i    (cur_q),
    .halted_i (scan_mask),
    .pick_o   (pick),
    .found_o  (found)
  );

  ts_quantum #(.QW(QW)) u_quantum (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (q_load),
    .dec_i     (q_dec),
    .quantum_i (quantum),
    .rand_i    (rand_mode),
    .last_o    (q_last)
  );

  ts_ctx_store #(
    .NT(NT), .TW(TW), .PCW(PCW), .DW(DW), .NREG(NREG), .NFLAG(NFLAG),
    .SP_IDX(SP_IDX), .LOAD_ADDR(LOAD_ADDR), .STACK_TOP(STACK_TOP),
    .STACK_STEP(STACK_STEP)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (state_q == ST_SAVE),
    .wr_tid_i  (cur_q),
    .wr_data_i (ctx_in),
    .rd_tid_i  (cur_q),
    .rd_data_o (restore_ctx)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    nxt_d    = nxt_q;
    halted_d = halted_q;
    icnt_d   = accept ? icnt_q + ICW'(1) : icnt_q;
    unique case (state_q)
      ST_INIT:    state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_RUN;
      ST_SAVE: begin
        cur_d   = nxt_q;
        state_d = ST_RESTORE;
      end
      ST_RUN: begin
        if (is_halt) begin
          halted_d = scan_mask;
          if (found) begin
            cur_d   = pick;
            state_d = ST_RESTORE;
          end else begin
            state_d = ST_DONE;
          end
        end else if (is_yield || expire) begin
          nxt_d   = pick;
          state_d = ST_SAVE;
        end
      end
      ST_DONE:    state_d = ST_DONE;
      default:    state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_INIT;
      cur_q    <= '0;
      nxt_q    <= '0;
      halted_q <= '0;
      icnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      if (state_q == ST_RUN) begin
        nxt_q    <= nxt_d;
        halted_q <= halted_d;
      end
      if (accept) icnt_q <= icnt_d;
    end
  end

  assign cur_tid     = cur_q;
  assign save_stb    = (state_q == ST_SAVE);
  assign restore_stb = (state_q == ST_RESTORE);
  assign all_done    = (state_q == ST_DONE);
  assign insn_count  = icnt_q;

  // R3: a save is followed by exactly one restore
  a_r3_save_then_restore: assert property (@(posedge clk) disable iff (!rst_n)
    save_stb |=> (restore_stb && !save_stb));

  // R6: a thread being restored has never halted
  a_r6_restore_live: assert property (@(posedge clk) disable iff (!rst_n)
    restore_stb |-> !halted_q[cur_q]);

  // R6: a halt never triggers a save
  a_r6_halt_no_save: assert property (@(posedge clk) disable iff (!rst_n)
    is_halt |=> !save_stb);

  // R5: the picker only offers live threads
  a_r5_pick_live: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> !scan_mask[pick]);

  // R7: completion is final and freezes the outputs
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |=> (all_done && $stable(cur_tid) && $stable(insn_count)));

  // R9: nothing is counted outside the running state
  a_r9_no_count_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |=> $stable(insn_count));

endmodule

// File: tb/test_ts_switcher.sv
module test_ts_switcher;

  localparam int NT = 4, QW = 8, PCW = 16, DW = 32, NREG = 6, NFLAG = 6;
  localparam int SP_IDX = 4, ICW = 32, TW = 2;
  localparam int CW = PCW + NREG*DW + NFLAG;
  localparam int LOAD = 1000, TOP = 128000, STEP = 1000;
  localparam int WD_LIMIT = 20000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [QW-1:0]  quantum;
  logic           rand_mode;
  logic           retire;
  logic [1:0]     kind;
  logic [CW-1:0]  ctx_in;
  logic [TW-1:0]  cur_tid;
  logic           save_stb, restore_stb, all_done;
  logic [CW-1:0]  restore_ctx;
  logic [ICW-1:0] insn_count;

  always #4 clk = ~clk;

  ts_switcher i_ts_switcher (
    .clk(clk), .rst_n(rst_n), .quantum(quantum), .rand_mode(rand_mode),
    .retire(retire), .retire_kind(kind), .ctx_in(ctx_in), .cur_tid(cur_tid),
    .save_stb(save_stb), .restore_stb(restore_stb), .restore_ctx(restore_ctx),
    .all_done(all_done), .insn_count(insn_count)
  );

  int    checks = 0, errors = 0, cyc = 0;
  string phase = "R1";

  // behavioural reference: 0 start,1 restore,2 run,3 save,4 done
  int            m_state, m_cur, m_nxt, m_cnt, m_icnt;
  logic [15:0]   m_lfsr;
  logic [NT-1:0] m_halted;
  logic [CW-1:0] m_ctx [NT];

  function automatic logic [CW-1:0] init_ctx(int t);
    logic [CW-1:0] v = '0;
    v[PCW-1:0] = PCW'(LOAD);
    v[PCW + SP_IDX*DW +: DW] = DW'(TOP - STEP*t);
    return v;
  endfunction

  function automatic int next_live(int c, logic [NT-1:0] h);
    for (int k = 1; k <= NT; k++) if (!h[(c + k) % NT]) return (c + k) % NT;
    return -1;
  endfunction

  function automatic int refill();
    int q = (quantum == 0) ? 1 : int'(quantum);
    int v = rand_mode ? (int'(m_lfsr) % q) + 1 : q;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cur = 0; m_nxt = 0; m_cnt = 0; m_icnt = 0;
      m_lfsr = 16'hACE1; m_halted = '0;
      for (int t = 0; t < NT; t++) m_ctx[t] = init_ctx(t);
    end else begin
      case (m_state)
        0: begin m_cnt = refill(); m_state = 1; end
        1: m_state = 2;
        3: begin m_ctx[m_cur] = ctx_in; m_cur = m_nxt; m_state = 1; end
        2: if (retire) begin
          m_icnt++;
          if (kind == 2'd2) begin
            m_halted[m_cur] = 1'b1;
            if (m_halted == '1) m_state = 4;
            else begin m_cur = next_live(m_cur, m_halted); m_cnt = refill(); m_state = 1; end
          end else if (kind == 2'd1 || m_cnt == 1) begin
            m_nxt = next_live(m_cur, m_halted); m_cnt = refill(); m_state = 3;
          end else m_cnt--;
        end
        default: ;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    ctx_in <= CW'({8{cyc * 32'h9E3779B1}});
    check(cur_tid == TW'(m_cur), phase, "cur_tid", 256'(cur_tid), 256'(m_cur));
    check(save_stb == (m_state == 3), phase, "save_stb", 256'(save_stb), 256'(m_state == 3));
    check(restore_stb == (m_state == 1), phase, "restore_stb", 256'(restore_stb), 256'(m_state == 1));
    check(all_done == (m_state == 4), (phase == "R7") ? "R7" : phase, "all_done",
          256'(all_done), 256'(m_state == 4));
    check(insn_count == ICW'(m_icnt), "R12", "insn_count", 256'(insn_count), 256'(m_icnt));
    if (m_state == 1)
      check(restore_ctx == m_ctx[m_cur], (phase == "R2") ? "R2" : "R8", "restore_ctx",
            256'(restore_ctx), 256'(m_ctx[m_cur]));
    if (cyc >= WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int n, input logic r, input logic [1:0] k);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); retire = r; kind = k;
    end
  endtask

  task automatic halt_when(input int t);
    forever begin
      @(negedge clk);
      if (m_state == 2 && m_cur == t) begin retire = 1'b1; kind = 2'd2; break; end
      retire = 1'b1; kind = 2'd0;
    end
    @(negedge clk); retire = 1'b0; kind = 2'd0;
  endtask

  initial begin
    rst_n = 1'b0; retire = 1'b0; kind = 2'd0; quantum = 8'd3; rand_mode = 1'b0;
    ctx_in = '0;
    phase = "R1";
    run(3, 1'b1, 2'd0);
    @(negedge clk); rst_n = 1'b1; retire = 1'b0;
    check(cur_tid == 0 && !save_stb && !restore_stb, "R1", "first cycle after reset",
          256'({save_stb, restore_stb}), 256'(0));
    @(negedge clk);
    check(restore_stb == 1'b1 && cur_tid == 0, "R1", "first restore of thread 0",
          256'(restore_stb), 256'(1));
    phase = "R2"; run(20, 1'b1, 2'd0);
    phase = "R3"; run(20, 1'b1, 2'd0);
    phase = "R8"; run(15, 1'b1, 2'd3);
    phase = "R4";
    for (int i = 0; i < 12; i++) begin run(2, 1'b1, 2'd0); run(1, 1'b1, 2'd1); end
    phase = "R9"; run(25, 1'b1, 2'd1);
    phase = "R5";
    for (int i = 0; i < 20; i++) begin run(1, 1'b1, 2'd0); run(1, 1'b0, 2'd0); end
    phase = "R11"; quantum = 8'd0; run(20, 1'b1, 2'd0);
    phase = "R10"; rand_mode = 1'b1; quantum = 8'd5; run(60, 1'b1, 2'd0);
    quantum = 8'd7; run(50, 1'b1, 2'd0);
    rand_mode = 1'b0; quantum = 8'd2;
    phase = "R6"; halt_when(2); run(20, 1'b1, 2'd0);
    halt_when(0); run(20, 1'b1, 2'd1);
    phase = "R5"; halt_when(3); run(15, 1'b1, 2'd1); run(10, 1'b1, 2'd0);
    phase = "R7"; halt_when(1);
    run(10, 1'b1, 2'd0);
    check(all_done == 1'b1, "R7", "completion flag", 256'(all_done), 256'(1));
    check(insn_count == ICW'(m_icnt), "R9", "no count after completion",
          256'(insn_count), 256'(m_icnt));
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule